// File: doc/BRIEF.md
# Translation Lookaside Buffer with Line Shootdown

This block is a small fully associative translation cache for an I/O address translation unit that works on 4 KB pages. It keeps recently used 32-bit page table entries, each tagged by its virtual page number. A requester presents a virtual page number and one cycle later sees either a hit with the cached entry or a miss. On a miss, an external table walker delivers the missing entry through the fill port. Fills replace slots in round-robin order, and a fill for a page number that is already cached overwrites that entry in place.

Software controls the cache through a small register interface. Writing one control bit empties the whole cache. Writing the shootdown register drops every entry that belongs to one aligned group of four consecutive pages. Each operation raises its own busy flag, and that flag reads back for exactly two cycles. While an operation is pending or busy, fills are discarded and lookups are stalled. Three statistics counters record hits, misses and stalls. Counting can be switched on or off, and a single write zeroes all three counters.

Top module: `xlat_tlb`

## Requirements
- R1: A lookup presented in cycle N shows its result after the next clock edge for one cycle. `lookupHit` is 1 with `lookupPte` equal to the cached entry when a valid entry holds that page number. Otherwise `lookupMiss` is 1 and `lookupPte` is 0.
- R2: Accepted fills of a new page number go to slots in round-robin order, starting at slot 0 after reset. With 16 slots, the 17th distinct fill evicts the first. A fill whose page number is already cached overwrites that entry's data and does not advance the replacement order.
- R3: Writing 1 to control bit 2 (register offset 0x00) empties the cache. Control bit 7 reads 1 in the two cycles that follow the write edge and 0 from the third cycle on. After the clear, every lookup misses.
- R4: Writing the shootdown register (offset 0x18) with bit 30 set starts a shootdown. Bits 19:0 carry a page index, and its bits 1:0 are ignored. Entries whose page number matches the index in bits 19:2 are dropped, and all other entries stay. The register reads back bit 31 as busy with the same two-cycle timing as R3, bit 30 as 0, and bits 19:0 as the index.
- R5: A fill presented in the cycle of a clear or shootdown request write, or while either busy flag is set, is discarded.
- R6: A lookup presented in the cycle of a request write, or while busy, produces `lookupStall` for one cycle with neither hit nor miss. At most one of hit, miss and stall is 1 in any cycle.
- R7: While control bit 1 is 1, the counters at offsets 0x08, 0x0C and 0x10 count hits, misses and stalls respectively. While control bit 1 is 0, the counters hold their values. Control bit 1 reads back as written.
- R8: Writing 1 to control bit 3 sets all three counters to 0.
- R9: After reset all entries are invalid, all counters and control fields read 0, and no lookup output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Lookup request |
| lookupVpn | input | VPN_W | Virtual page number to look up |
| lookupHit | output | 1 | Lookup hit, one cycle after request |
| lookupMiss | output | 1 | Lookup miss, one cycle after request |
| lookupStall | output | 1 | Lookup stalled by invalidation |
| lookupPte | output | PTE_W | Cached entry on hit, 0 otherwise |
| fillValid | input | 1 | Fill from table walker |
| fillVpn | input | VPN_W | Page number of the fill |
| fillPte | input | PTE_W | Entry to store |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte offset |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data, combinational from regAddr |

## Verification
Lookup results, including stalls, are registered. The bench therefore drives a request at a falling edge and samples the outputs at the next falling edge, one rising edge later. Register reads are combinational, so the bench samples them shortly after it sets the address. Busy flags are sampled at the first, second and third falling edges after the request write, where the expected values are 1, 1 and 0. Fills and lookups are placed in the request-write cycle and in the busy window to show that fills are discarded and lookups stall in both. A bench-side model of the slots, the replacement pointer and the counters supplies every expected hit, miss, entry and count.

// File: rtl/xlat_tlb_pkg.sv
package xlat_tlb_pkg;
  // register byte offsets (software-visible map)
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_HIT   = 'h08;
  localparam int OFS_MISS  = 'h0C;
  localparam int OFS_STALL = 'h10;
  localparam int OFS_SHOOT = 'h18;
  // control bits
  localparam int CTL_STATS_EN  = 1;
  localparam int CTL_CLEAR     = 2;
  localparam int CTL_STATS_CLR = 3;
  localparam int CTL_CLEARING  = 7;
  // shootdown bits
  localparam int SHT_REQ  = 30;
  localparam int SHT_BUSY = 31;

  typedef struct packed {
    logic invAll;   // empty every slot at the next edge
    logic invLine;  // drop slots of one four-page group at the next edge
    logic block;    // fills dropped, lookups stalled
  } tlbStrobes_t;

  typedef enum logic [1:0] {INV_IDLE, INV_APPLY, INV_DRAIN} invState_t;
endpackage

// File: rtl/xlat_tlb_ctrl.sv
module xlat_tlb_ctrl
  import xlat_tlb_pkg::*;
#(
  parameter int VPN_W  = 20,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              lookupValid,
  input  logic              hitNow,
  input  logic              missNow,
  output tlbStrobes_t       strobes,
  output logic [VPN_W-1:0]  lineTag
);
  localparam int N_CNT = 3;

  invState_t        invState;
  logic             invIsShoot;
  logic             statsEn;
  logic [VPN_W-1:0] shootIdx;
  logic [CNT_W-1:0] cntQ [N_CNT];
  logic [N_CNT-1:0] cntEvt;
  logic wrCtrl, wrShoot, clrReq, shootReq, busyAny, startInv;
  logic clearBusy, shootBusy, statsClr;

  assign wrCtrl    = regWrEn && (regAddr == ADDR_W'(OFS_CTRL));
  assign wrShoot   = regWrEn && (regAddr == ADDR_W'(OFS_SHOOT));
  assign clrReq    = wrCtrl && regWrData[CTL_CLEAR];
  assign shootReq  = wrShoot && regWrData[SHT_REQ];
  assign statsClr  = wrCtrl && regWrData[CTL_STATS_CLR];
  assign busyAny   = (invState != INV_IDLE);
  assign startInv  = (clrReq || shootReq) && !busyAny;
  assign clearBusy = busyAny && !invIsShoot;
  assign shootBusy = busyAny && invIsShoot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      invState   <= INV_IDLE;
      invIsShoot <= 1'b0;
      shootIdx   <= '0;
      statsEn    <= 1'b0;
    end else begin
      case (invState)
        INV_IDLE: if (startInv) begin
          invState   <= INV_APPLY;
          invIsShoot <= shootReq;
          if (shootReq) shootIdx <= regWrData[VPN_W-1:0];
        end
        INV_APPLY: invState <= INV_DRAIN;
        default:   invState <= INV_IDLE;
      endcase
      if (wrCtrl) statsEn <= regWrData[CTL_STATS_EN];
    end
  end

  always_comb begin
    strobes.invAll  = (invState == INV_APPLY) && !invIsShoot;
    strobes.invLine = (invState == INV_APPLY) && invIsShoot;
    strobes.block   = clrReq || shootReq || busyAny;
  end
  assign lineTag = shootIdx;

  // event order: hit, miss, stall
  assign cntEvt = {lookupValid && strobes.block, missNow, hitNow};

  for (genvar g = 0; g < N_CNT; g++) begin : gCnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             cntQ[g] <= '0;
      else if (statsClr)     cntQ[g] <= '0;
      else if (statsEn && cntEvt[g]) cntQ[g] <= cntQ[g] + CNT_W'(1);
    end
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (!statsEn && !statsClr) |=> $stable(cntQ[g])); // R7
    AST_CNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      statsClr |=> (cntQ[g] == '0)); // R8
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == ADDR_W'(OFS_CTRL)) begin
      regRdData[CTL_STATS_EN] = statsEn;
      regRdData[CTL_CLEARING] = clearBusy;
    end else if (regAddr == ADDR_W'(OFS_HIT))   regRdData = DATA_W'(cntQ[0]);
    else if (regAddr == ADDR_W'(OFS_MISS))      regRdData = DATA_W'(cntQ[1]);
    else if (regAddr == ADDR_W'(OFS_STALL))     regRdData = DATA_W'(cntQ[2]);
    else if (regAddr == ADDR_W'(OFS_SHOOT)) begin
      regRdData[VPN_W-1:0] = shootIdx;
      regRdData[SHT_BUSY]  = shootBusy;
    end
  end

  AST_CLEAR_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (clearBusy && $past(clearBusy)) |=> !clearBusy); // R3
  AST_SHOOT_BUSY_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (shootBusy && $past(shootBusy)) |=> !shootBusy); // R4
endmodule

// File: rtl/xlat_tlb_store.sv
module xlat_tlb_store
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PTE_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  tlbStrobes_t      strobes,
  input  logic [VPN_W-1:0] lineTag,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PTE_W-1:0] fillPte,
  output logic             hitNow,
  output logic             missNow,
  output logic             lookupHit,
  output logic             lookupMiss,
  output logic             lookupStall,
  output logic [PTE_W-1:0] lookupPte
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   vpnQ [ENTRIES];
  logic [PTE_W-1:0]   pteQ [ENTRIES];
  logic [IDX_W-1:0]   ptrQ;
  logic [ENTRIES-1:0] lkMatch, flMatch, lineMatch;
  logic [PTE_W-1:0]   lkPte;
  logic fillEn, flAny, lkAny;

  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign lkMatch[g]   = validQ[g] && (vpnQ[g] == lookupVpn);
    assign flMatch[g]   = validQ[g] && (vpnQ[g] == fillVpn);
    assign lineMatch[g] = (vpnQ[g][VPN_W-1:2] == lineTag[VPN_W-1:2]);
  end

  assign fillEn  = fillValid && !strobes.block;
  assign flAny   = |flMatch;
  assign lkAny   = |lkMatch;
  assign hitNow  = lookupValid && !strobes.block && lkAny;
  assign missNow = lookupValid && !strobes.block && !lkAny;

  always_comb begin
    lkPte = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (lkMatch[i]) lkPte = lkPte | pteQ[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ      <= '0;
      ptrQ        <= '0;
      lookupHit   <= 1'b0;
      lookupMiss  <= 1'b0;
      lookupStall <= 1'b0;
      lookupPte   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i] <= '0;
        pteQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (strobes.invAll) validQ[i] <= 1'b0;
        else if (strobes.invLine && lineMatch[i]) validQ[i] <= 1'b0;
        else if (fillEn && (flAny ? flMatch[i] : (ptrQ == IDX_W'(i)))) begin
          validQ[i] <= 1'b1;
          vpnQ[i]   <= fillVpn;
          pteQ[i]   <= fillPte;
        end
      end
      if (fillEn && !flAny)
        ptrQ <= (ptrQ == IDX_W'(ENTRIES-1)) ? '0 : ptrQ + IDX_W'(1);
      lookupHit   <= hitNow;
      lookupMiss  <= missNow;
      lookupStall <= lookupValid && strobes.block;
      lookupPte   <= hitNow ? lkPte : '0;
    end
  end

  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch)); // R2
  AST_EXCL_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    $countones({lookupHit, lookupMiss, lookupStall}) <= 1); // R6
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.invAll |=> (validQ == '0)); // R3
  AST_LINE_GONE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.invLine |=> ((validQ & $past(lineMatch)) == '0)); // R4
  AST_NO_FILL_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.block && !strobes.invAll && !strobes.invLine) |=> $stable(validQ)); // R5
endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PTE_W   = 32,
  parameter int CNT_W   = 32,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  output logic              lookupHit,
  output logic              lookupMiss,
  output logic              lookupStall,
  output logic [PTE_W-1:0]  lookupPte,
  input  logic              fillValid,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PTE_W-1:0]  fillPte,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData
);
  tlbStrobes_t      strobes;
  logic [VPN_W-1:0] lineTag;
  logic             hitNow, missNow;

  xlat_tlb_ctrl #(.VPN_W(VPN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .lookupValid(lookupValid),
    .hitNow(hitNow), .missNow(missNow), .strobes(strobes), .lineTag(lineTag)
  );

  xlat_tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PTE_W(PTE_W)) uStore (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lineTag(lineTag),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPte(fillPte), .hitNow(hitNow), .missNow(missNow),
    .lookupHit(lookupHit), .lookupMiss(lookupMiss), .lookupStall(lookupStall),
    .lookupPte(lookupPte)
  );
endmodule

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lookupValid = 1'b0;
  logic [19:0] lookupVpn = '0;
  logic lookupHit, lookupMiss, lookupStall;
  logic [31:0] lookupPte;
  logic fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [31:0] fillPte = '0;
  logic regWrEn = 1'b0;
  logic [5:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  always #5 clk = ~clk;

  xlat_tlb dut (.*);

  int checks = 0;
  int errors = 0;

  // bench model built from the requirements
  bit          mValid [N];
  logic [19:0] mVpn [N];
  logic [31:0] mPte [N];
  int          mPtr = 0;
  bit          mStatsEn = 0;
  int          mCnt [3];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelFill(input logic [19:0] vpn, input logic [31:0] pte);
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == vpn) begin
        mPte[i] = pte;
        return;
      end
    mValid[mPtr] = 1; mVpn[mPtr] = vpn; mPte[mPtr] = pte;
    mPtr = (mPtr + 1) % N;
  endtask

  task automatic doFill(input logic [19:0] vpn, input logic [31:0] pte);
    fillValid = 1; fillVpn = vpn; fillPte = pte;
    @(negedge clk);
    fillValid = 0;
    modelFill(vpn, pte);
  endtask

  task automatic doLookup(input logic [19:0] vpn);
    bit eh; logic [31:0] ep;
    eh = 0; ep = '0;
    for (int i = 0; i < N; i++)
      if (mValid[i] && mVpn[i] == vpn) begin eh = 1; ep = mPte[i]; end
    lookupValid = 1; lookupVpn = vpn;
    @(negedge clk);
    lookupValid = 0;
    check(lookupHit == eh && lookupMiss == !eh && !lookupStall, "R1 hit/miss",
          {29'd0, lookupStall, lookupMiss, lookupHit}, {30'd0, !eh, eh});
    check(lookupPte == ep, "R1 entry", lookupPte, ep);
    if (mStatsEn) begin
      if (eh) mCnt[0]++; else mCnt[1]++;
    end
  endtask

  task automatic regWr(input logic [5:0] a, input logic [31:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 0;
    if (a == 6'h00) mStatsEn = d[1];
    if (a == 6'h00 && d[3]) begin mCnt[0] = 0; mCnt[1] = 0; mCnt[2] = 0; end
  endtask

  task automatic regRd(input logic [5:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic checkCounters(input string tag);
    logic [31:0] v;
    regRd(6'h08, v); check(v == mCnt[0], {tag, " hit count"}, v, mCnt[0]);
    regRd(6'h0C, v); check(v == mCnt[1], {tag, " miss count"}, v, mCnt[1]);
    regRd(6'h10, v); check(v == mCnt[2], {tag, " stall count"}, v, mCnt[2]);
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < N; i++) begin mValid[i] = 0; mVpn[i] = '0; mPte[i] = '0; end
    for (int i = 0; i < 3; i++) mCnt[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R9: reset state
    check(!lookupHit && !lookupMiss && !lookupStall, "R9 outputs idle",
          {29'd0, lookupStall, lookupMiss, lookupHit}, 0);
    regRd(6'h00, v); check(v == 0, "R9 control", v, 0);
    regRd(6'h18, v); check(v == 0, "R9 shootdown", v, 0);
    checkCounters("R9");
    doLookup(20'h00000);

    regWr(6'h00, 32'h2);
    regRd(6'h00, v); check(v == 32'h2, "R7 enable readback", v, 32'h2);

    // R1/R2: fill all slots, sweep hits and misses
    for (int i = 0; i < N; i++) doFill(20'h200 + 20'(i), 32'hA000_0000 | 32'(i * 7 + 1));
    for (int i = 0; i < N; i++) doLookup(20'h200 + 20'(i));
    for (int i = 0; i < N; i++) doLookup(20'h400 + 20'(i * 3));

    // R2: eviction order and in-place overwrite
    doFill(20'h210, 32'h1234_5678);
    doLookup(20'h200);
    check(!lookupHit, "R2 first slot evicted", {31'd0, lookupHit}, 0);
    doLookup(20'h210);
    doFill(20'h205, 32'h5555_AAAA);
    doLookup(20'h205);
    check(lookupPte == 32'h5555_AAAA, "R2 overwrite in place", lookupPte, 32'h5555_AAAA);
    doFill(20'h211, 32'h0BAD_F00D);
    doLookup(20'h201);
    check(!lookupHit, "R2 second slot evicted", {31'd0, lookupHit}, 0);
    for (int i = 0; i < 18; i++) doLookup(20'h200 + 20'(i));

    // R4/R5/R6: shootdown with fill in request cycle and during busy
    regWrEn = 1; regAddr = 6'h18; regWrData = 32'h4000_0205;
    fillValid = 1; fillVpn = 20'h300; fillPte = 32'h3;
    @(negedge clk);
    regWrEn = 0; fillValid = 0;
    #1 check(regRdData == 32'h8000_0205, "R4 busy cycle 1", regRdData, 32'h8000_0205);
    lookupValid = 1; lookupVpn = 20'h200;
    @(negedge clk);
    check(lookupStall && !lookupHit && !lookupMiss, "R6 stall during busy",
          {29'd0, lookupStall, lookupMiss, lookupHit}, 32'h4);
    #1 check(regRdData == 32'h8000_0205, "R4 busy cycle 2", regRdData, 32'h8000_0205);
    lookupValid = 0;
    fillValid = 1; fillVpn = 20'h301; fillPte = 32'h4;
    @(negedge clk);
    fillValid = 0;
    #1 check(regRdData == 32'h0000_0205, "R4 busy released", regRdData, 32'h0000_0205);
    if (mStatsEn) mCnt[2]++;
    for (int i = 0; i < N; i++)
      if (mVpn[i][19:2] == 18'(20'h205 >> 2)) mValid[i] = 0;
    for (int i = 0; i < 18; i++) doLookup(20'h200 + 20'(i));
    doLookup(20'h300);
    check(!lookupHit, "R5 fill in request cycle dropped", {31'd0, lookupHit}, 0);
    doLookup(20'h301);
    check(!lookupHit, "R5 fill while busy dropped", {31'd0, lookupHit}, 0);

    // R3/R6: full clear, stall in request cycle
    regWrEn = 1; regAddr = 6'h00; regWrData = 32'h6;
    lookupValid = 1; lookupVpn = 20'h208;
    @(negedge clk);
    regWrEn = 0; lookupValid = 0;
    check(lookupStall && !lookupHit, "R6 stall in request cycle",
          {29'd0, lookupStall, lookupMiss, lookupHit}, 32'h4);
    #1 check(regRdData == 32'h82, "R3 clearing cycle 1", regRdData, 32'h82);
    @(negedge clk);
    #1 check(regRdData == 32'h82, "R3 clearing cycle 2", regRdData, 32'h82);
    @(negedge clk);
    #1 check(regRdData == 32'h02, "R3 clearing released", regRdData, 32'h02);
    if (mStatsEn) mCnt[2]++;
    for (int i = 0; i < N; i++) mValid[i] = 0;
    for (int i = 0; i < 18; i++) doLookup(20'h200 + 20'(i));
    checkCounters("R7");

    // R7: counting disabled holds counters
    regWr(6'h00, 32'h0);
    doFill(20'h0AB, 32'h77);
    doLookup(20'h0AB);
    doLookup(20'h0AC);
    checkCounters("R7 disabled");

    // R8: counter clear
    regWr(6'h00, 32'h8);
    checkCounters("R8");

    finishRun();
  end
endmodule